// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Interlock

This block holds the hazard logic of a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. It also holds a small datapath around that logic so the logic can be exercised end to end. The datapath has a register file, the four pipeline registers, an adder as the ALU and an arithmetic stand-in for data memory.

Two checks run every cycle. The first compares the source registers of the instruction in execute with the destinations still held in the two later pipeline registers. From that comparison it picks, for each ALU operand, one of three values: the register-file value, the newest ALU result, or the write-back value. The second check finds a load in execute whose destination is read by the instruction in decode. When that happens it freezes the fetch side for one cycle and sends an empty slot into execute.

Instructions arrive on a valid/ready stream. `instr_ready` is the fetch-advance and decode-register write enable. When it is low, the source must hold the offered instruction unchanged until a cycle in which both `instr_valid` and `instr_ready` are high. A cycle with `instr_valid` low and `instr_ready` high puts an empty slot into decode.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After reset, `instr_ready` is 1, `stall`, `bubble` and `ex_valid` are 0, and both select outputs are 00. Register i holds the value i, and register 0 always reads as zero.
- R2: Operand select codes: 00 takes the value read in decode, 10 takes the ALU result held after execute, and 01 takes the value held after the memory stage (load data or an older ALU result). The value 11 never appears.
- R3: Operand A selects 10 when the instruction after execute writes a register, its destination is nonzero, and that destination equals A's source register. Operand B follows the same rule with its own source register.
- R4: An operand selects 01 when the instruction after the memory stage writes a nonzero destination equal to that operand's source register, and the R3 match does not also hold for that operand. When both match, 10 wins.
- R5: Register 0 never causes a forwarding select or a stall.
- R6: `stall` is high, in the same cycle and combinationally, when the instruction in execute is a load with a nonzero destination and the instruction in decode reads that register as either source.
- R7: While `stall` is high, `instr_ready` is low and the decode register keeps its content. In the next cycle `bubble` is 1, `ex_valid` is 0 and both selects are 00.
- R8: A load followed directly by a dependent instruction costs exactly one stall cycle, and `stall` is never high two cycles in a row. After the stall, the dependent instruction receives the load data through select 01.
- R9: An instruction is accepted on a rising edge where `instr_valid` and `instr_ready` are both high. Opcode 01 is an add and 10 is a load; 00 and 11 occupy a slot without writing. Each accepted add or load shows `ex_valid` high in exactly one later cycle, in program order.
- R10: With `ex_valid` high, `ex_opnd_a` and `ex_opnd_b` equal the values the source registers hold under one-at-a-time execution. An add writes rs+rt into rd. A load writes ((rs+rt) shifted left one bit, truncated to XLEN) XOR LOAD_KEY. A value written back is readable in decode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | Instruction accepted at the next edge; low during a stall |
| instr_op | input | 2 | 01 add, 10 load, other values empty |
| instr_rd | input | $clog2(NREG) | Destination register |
| instr_rs | input | $clog2(NREG) | First source register (operand A) |
| instr_rt | input | $clog2(NREG) | Second source register (operand B) |
| fwd_sel_a | output | 2 | Select code of operand A |
| fwd_sel_b | output | 2 | Select code of operand B |
| stall | output | 1 | Load-use interlock active this cycle |
| bubble | output | 1 | Execute holds an inserted empty slot |
| ex_valid | output | 1 | Execute holds an accepted add or load |
| ex_opnd_a | output | XLEN | Operand A after selection |
| ex_opnd_b | output | XLEN | Operand B after selection |

## Verification
The hardest case to reach from the ports is a select conflict. Both later pipeline registers must hold the same destination while the instruction in execute reads it, and it must line up with a load whose result arrives only after a stall. A directed prologue builds exactly these cases: a load followed by a double use, a chain where both stages match one source, and loads to and reads from register 0. A long random stream then follows, with register indices drawn mostly from four registers, about one load in three, and idle cycles mixed in. This brings back-to-back dependencies and idle gaps that break adjacency. The bench tracks the occupant of every pipeline slot from the handshake alone. It compares selects, stall and bubble each cycle, and compares the operand values in execute with a one-at-a-time reference register file.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_REGF = 2'b00,
    FWD_WBK  = 2'b01,
    FWD_ALU  = 2'b10
  } fwd_sel_e;

  typedef enum logic [1:0] {
    OPC_NOP  = 2'b00,
    OPC_ADD  = 2'b01,
    OPC_LOAD = 2'b10
  } opc_e;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic                 em_wr,
  input  logic [RW-1:0]        em_rd,
  input  logic                 mw_wr,
  input  logic [RW-1:0]        mw_rd,
  input  logic [1:0][RW-1:0]   src,
  output logic [1:0][1:0]      sel
);
  for (genvar g = 0; g < 2; g++) begin : g_opnd
    logic hit_em, hit_mw;
    always_comb begin
      hit_em = em_wr && (em_rd != '0) && (em_rd == src[g]);
      hit_mw = mw_wr && (mw_rd != '0) && (mw_rd == src[g]);
      if (hit_em)      sel[g] = FWD_ALU;
      else if (hit_mw) sel[g] = FWD_WBK;
      else             sel[g] = FWD_REGF;
    end
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int RW = 3
) (
  input  logic          ld_in_ex,
  input  logic [RW-1:0] ld_rd,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  output logic          stall
);
  always_comb
    stall = ld_in_ex && (ld_rd != '0) && ((ld_rd == id_rs) || (ld_rd == id_rt));
endmodule

// File: rtl/hz_regfile.sv
module hz_regfile #(
  parameter int XLEN = 16,
  parameter int NREG = 8,
  parameter int RW   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [RW-1:0]         wa,
  input  logic [XLEN-1:0]       wd,
  input  logic [1:0][RW-1:0]    ra,
  output logic [1:0][XLEN-1:0]  rdata
);
  logic [XLEN-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= XLEN'(i);
    end else if (we && (wa != '0)) begin
      rf[wa] <= wd;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_rd
    always_comb begin
      if (ra[g] == '0)                      rdata[g] = '0;
      else if (we && (wa == ra[g]))         rdata[g] = wd;
      else                                  rdata[g] = rf[ra[g]];
    end
  end
endmodule

// File: rtl/hz_opnd_mux.sv
module hz_opnd_mux
  import hz_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [1:0]      sel,
  input  logic [XLEN-1:0] rf_val,
  input  logic [XLEN-1:0] em_val,
  input  logic [XLEN-1:0] mw_val,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (sel)
      FWD_ALU: y = em_val;
      FWD_WBK: y = mw_val;
      default: y = rf_val;
    endcase
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hz_pkg::*;
#(
  parameter int              XLEN     = 16,
  parameter int              NREG     = 8,
  parameter logic [XLEN-1:0] LOAD_KEY = XLEN'(16'h5A3C),
  localparam int             RW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic [1:0]      instr_op,
  input  logic [RW-1:0]   instr_rd,
  input  logic [RW-1:0]   instr_rs,
  input  logic [RW-1:0]   instr_rt,
  output logic [1:0]      fwd_sel_a,
  output logic [1:0]      fwd_sel_b,
  output logic            stall,
  output logic            bubble,
  output logic            ex_valid,
  output logic [XLEN-1:0] ex_opnd_a,
  output logic [XLEN-1:0] ex_opnd_b
);
  // decode-stage register
  logic            ifid_v, ifid_ld;
  logic [RW-1:0]   ifid_rd, ifid_rs, ifid_rt;
  // execute-stage register
  logic            idex_v, idex_ld;
  logic [RW-1:0]   idex_rd, idex_rs, idex_rt;
  logic [XLEN-1:0] idex_va, idex_vb;
  // memory-stage register
  logic            em_v, em_ld;
  logic [RW-1:0]   em_rd;
  logic [XLEN-1:0] em_alu;
  // write-back register
  logic            mw_v;
  logic [RW-1:0]   mw_rd;
  logic [XLEN-1:0] mw_val;

  logic [1:0][XLEN-1:0] id_rdata;
  logic [1:0][1:0]      sel;
  logic [1:0][XLEN-1:0] opnd;
  logic [XLEN-1:0]      mem_res;
  logic                 accept, op_ok;

  assign instr_ready = !stall;
  assign accept      = instr_valid && instr_ready;
  assign op_ok       = (instr_op == OPC_ADD) || (instr_op == OPC_LOAD);

  hz_stall_unit #(.RW(RW)) u_stall (
    .ld_in_ex (idex_v && idex_ld),
    .ld_rd    (idex_rd),
    .id_rs    (ifid_rs),
    .id_rt    (ifid_rt),
    .stall    (stall)
  );

  hz_regfile #(.XLEN(XLEN), .NREG(NREG), .RW(RW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mw_v),
    .wa    (mw_rd),
    .wd    (mw_val),
    .ra    ({ifid_rt, ifid_rs}),
    .rdata (id_rdata)
  );

  hz_fwd_unit #(.RW(RW)) u_fwd (
    .em_wr (em_v),
    .em_rd (em_rd),
    .mw_wr (mw_v),
    .mw_rd (mw_rd),
    .src   ({idex_rt, idex_rs}),
    .sel   (sel)
  );

  for (genvar g = 0; g < 2; g++) begin : g_mux
    hz_opnd_mux #(.XLEN(XLEN)) u_mux (
      .sel    (sel[g]),
      .rf_val ((g == 0) ? idex_va : idex_vb),
      .em_val (em_alu),
      .mw_val (mw_val),
      .y      (opnd[g])
    );
  end

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];
  assign ex_opnd_a = opnd[0];
  assign ex_opnd_b = opnd[1];
  assign ex_valid  = idex_v;
  assign mem_res   = em_ld ? ({em_alu[XLEN-2:0], 1'b0} ^ LOAD_KEY) : em_alu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifid_v <= 1'b0; ifid_ld <= 1'b0;
      ifid_rd <= '0;  ifid_rs <= '0; ifid_rt <= '0;
      idex_v <= 1'b0; idex_ld <= 1'b0;
      idex_rd <= '0;  idex_rs <= '0; idex_rt <= '0;
      idex_va <= '0;  idex_vb <= '0;
      bubble <= 1'b0;
      em_v <= 1'b0; em_ld <= 1'b0; em_rd <= '0; em_alu <= '0;
      mw_v <= 1'b0; mw_rd <= '0; mw_val <= '0;
    end else begin
      if (instr_ready) begin
        ifid_v  <= accept && op_ok;
        ifid_ld <= accept && (instr_op == OPC_LOAD);
        ifid_rd <= accept ? instr_rd : '0;
        ifid_rs <= accept ? instr_rs : '0;
        ifid_rt <= accept ? instr_rt : '0;
      end
      if (stall) begin
        idex_v <= 1'b0; idex_ld <= 1'b0;
        idex_rd <= '0;  idex_rs <= '0; idex_rt <= '0;
        idex_va <= '0;  idex_vb <= '0;
      end else begin
        idex_v  <= ifid_v;  idex_ld <= ifid_ld;
        idex_rd <= ifid_rd; idex_rs <= ifid_rs; idex_rt <= ifid_rt;
        idex_va <= id_rdata[0];
        idex_vb <= id_rdata[1];
      end
      bubble <= stall;
      em_v   <= idex_v;
      em_ld  <= idex_ld;
      em_rd  <= idex_rd;
      em_alu <= opnd[0] + opnd[1];
      mw_v   <= em_v;
      mw_rd  <= em_rd;
      mw_val <= mem_res;
    end
  end

  // R7
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (bubble && !ex_valid && fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));
  // R7
  decode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(ifid_rs) && $stable(ifid_rt) && $stable(ifid_rd)));
  // R8
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  // R5
  zero_reg_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_sel_a != 2'b00) |-> (idex_rs != '0)) and ((fwd_sel_b != 2'b00) |-> (idex_rt != '0)));
  // R4
  newer_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a == FWD_WBK) |-> !(em_v && em_rd == idex_rs));
  // R2
  sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));
endmodule

// File: tb/pipe_hazard_unit_tb_top.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb_top;
  localparam int XLEN = 16;
  localparam int NREG = 8;
  localparam int RW   = 3;
  localparam logic [XLEN-1:0] KEY = 16'h5A3C;
  localparam int NDIR  = 9;
  localparam int TOTAL = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid, instr_ready, stall, bubble, ex_valid;
  logic [1:0] instr_op, fwd_sel_a, fwd_sel_b;
  logic [RW-1:0] instr_rd, instr_rs, instr_rt;
  logic [XLEN-1:0] ex_opnd_a, ex_opnd_b;

  always #2 clk = ~clk;

  pipe_hazard_unit #(.XLEN(XLEN), .NREG(NREG), .LOAD_KEY(KEY)) dut_i (.*);

  typedef struct packed { logic v; logic ld; logic [RW-1:0] rd, rs, rt; } slot_t;
  slot_t ifid_m, idex_m, em_m, mw_m;
  logic [XLEN-1:0] ref_rf [NREG];
  logic [XLEN-1:0] qa[$], qb[$];
  int errs = 0, checks = 0, stall_seen = 0, stall_pairs = 0;
  logic exp_stall = 1'b0, prev_exp_stall = 1'b0;
  logic [1:0] p_op; logic [RW-1:0] p_rd, p_rs, p_rt;
  int didx = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [XLEN-1:0] ld_fn(logic [XLEN-1:0] x);
    return XLEN'({x[XLEN-2:0], 1'b0}) ^ KEY;
  endfunction

  function automatic logic [1:0] exp_sel(slot_t em, slot_t mw, logic [RW-1:0] src);
    if (em.v && em.rd != 0 && em.rd == src) return 2'b10;
    if (mw.v && mw.rd != 0 && mw.rd == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(slot_t em, logic [RW-1:0] src);
    if (src == 0) return "R5";
    if (em.v && em.rd == src) return "R3";
    return "R4";
  endfunction

  // {op, rd, rs, rt}
  function automatic logic [11:0] dir_entry(int i);
    case (i)
      0: return {2'b10, 3'd1, 3'd2, 3'd3}; // load r1
      1: return {2'b01, 3'd4, 3'd1, 3'd1}; // use r1 at once: stall (R8)
      2: return {2'b01, 3'd5, 3'd4, 3'd1};
      3: return {2'b01, 3'd5, 3'd5, 3'd5};
      4: return {2'b01, 3'd6, 3'd5, 3'd4}; // r5 in both later stages
      5: return {2'b10, 3'd0, 3'd1, 3'd2}; // load to r0
      6: return {2'b01, 3'd7, 3'd0, 3'd0}; // no stall on r0 (R5)
      7: return {2'b01, 3'd0, 3'd3, 3'd3};
      default: return {2'b01, 3'd2, 3'd0, 3'd3};
    endcase
  endfunction

  task automatic pick();
    if (didx < NDIR) begin
      {p_op, p_rd, p_rs, p_rt} = dir_entry(didx);
      didx++;
    end else begin
      p_op = ($urandom % 100 < 30) ? 2'b10 : 2'b01;
      p_rd = ($urandom % 4 == 0) ? RW'($urandom % NREG) : RW'($urandom % 4);
      p_rs = ($urandom % 4 == 0) ? RW'($urandom % NREG) : RW'($urandom % 4);
      p_rt = ($urandom % 4 == 0) ? RW'($urandom % NREG) : RW'($urandom % 4);
    end
  endtask

  task automatic push_ref(logic [1:0] op, logic [RW-1:0] rd, logic [RW-1:0] rs, logic [RW-1:0] rt);
    logic [XLEN-1:0] a, b, s;
    a = ref_rf[rs];
    b = ref_rf[rt];
    qa.push_back(a);
    qb.push_back(b);
    s = a + b;
    if (rd != 0) ref_rf[rd] = (op == 2'b10) ? ld_fn(s) : s;
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int issued, drain;
    logic have, hold, pv, rdy, acc;
    void'($urandom(32'h1F2E));
    for (int i = 0; i < NREG; i++) ref_rf[i] = XLEN'(i);
    ifid_m = '0; idex_m = '0; em_m = '0; mw_m = '0;
    instr_valid = 1'b0; instr_op = '0; instr_rd = '0; instr_rs = '0; instr_rt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk("R1 ready", instr_ready, 1);
    chk("R1 stall", stall, 0);
    chk("R1 bubble", bubble, 0);
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 sel", {fwd_sel_a, fwd_sel_b}, 0);
    issued = 0; drain = 10; have = 1'b1; hold = 1'b0;
    pick();
    while (have || drain > 0) begin
      if (have) pv = hold ? 1'b1 : ((didx <= NDIR) ? 1'b1 : ($urandom % 100 < 85));
      else      pv = 1'b0;
      instr_valid = pv;
      instr_op = p_op; instr_rd = p_rd; instr_rs = p_rs; instr_rt = p_rt;
      rdy = instr_ready;
      @(negedge clk);
      acc = pv && rdy;
      mw_m = em_m;
      em_m = idex_m;
      idex_m = prev_exp_stall ? '0 : ifid_m;
      if (rdy) ifid_m = acc ? slot_t'({1'b1, p_op == 2'b10, p_rd, p_rs, p_rt}) : '0;
      if (acc) push_ref(p_op, p_rd, p_rs, p_rt);
      exp_stall = idex_m.v && idex_m.ld && idex_m.rd != 0 &&
                  (idex_m.rd == ifid_m.rs || idex_m.rd == ifid_m.rt);
      if (exp_stall) stall_pairs++;
      if (stall) stall_seen++;
      chk((idex_m.ld && idex_m.rd == 0) ? "R5 stall" : "R6 stall", stall, exp_stall);
      chk("R7 ready", instr_ready, !exp_stall);
      chk("R7 bubble", bubble, prev_exp_stall);
      if (prev_exp_stall) chk("R8 no second stall", stall, 0);
      chk({sel_tag(em_m, idex_m.rs), " sel_a"}, fwd_sel_a, exp_sel(em_m, mw_m, idex_m.rs));
      chk({sel_tag(em_m, idex_m.rt), " sel_b"}, fwd_sel_b, exp_sel(em_m, mw_m, idex_m.rt));
      chk("R9 ex_valid", ex_valid, idex_m.v);
      if (ex_valid) begin
        if (qa.size() == 0) begin
          chk("R9 unexpected instruction in EX", 1, 0);
        end else begin
          chk("R2 R10 opnd_a", ex_opnd_a, qa.pop_front());
          chk("R2 R10 opnd_b", ex_opnd_b, qb.pop_front());
        end
      end
      prev_exp_stall = exp_stall;
      if (acc) begin
        issued++;
        hold = 1'b0;
        if (issued < TOTAL + NDIR) pick(); else have = 1'b0;
      end else begin
        hold = pv;
      end
      if (!have) drain--;
    end
    chk("R9 all instructions reached EX", qa.size(), 0);
    chk("R8 stall cycle total", stall_seen, stall_pairs);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule